// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave-side command engine of a three-wire serial EEPROM holding 512 words of 16 bits. The chip select (active low), serial clock and serial data input arrive asynchronously. They are synchronised into a fast system clock, and the block works from the detected edges of the serial clock. It gathers a 16-bit command frame and checks its opening start pattern. It then decodes one of four commands and keeps a latch that arms programming.

A READ fetches words through a registered read port to an external word array and shifts them out least significant bit first. The output keeps streaming later words as long as the serial clock runs. A WRITE collects a data word and hands the address and word to a separate program-cycle controller as a one-cycle request. While chip select is low and no read is streaming, the data output shows the ready/busy state of that controller.

Timing assumption: each serial clock phase lasts at least five system clocks. The external array returns `mem_rdata` for `mem_addr` one system clock after the address is presented.

Top module: `serial_eeprom_front`

## Requirements
- R1: The first four bits after chip select falls must be 1,0,1,0 (first bit first). On any mismatch the rest of the frame is ignored until chip select goes high.
- R2: In a READ frame, bits 5..7 are 1,0,0. Bit 8 is address bit 0, and bits 9..16 carry address bits 1..8 in that order. The word's bit 0 drives the data output after the falling clock edge that follows the 16th rising edge, and bits 1..15 follow on successive falling edges.
- R3: While the serial clock keeps running in a READ, the word at the next address follows every further 16 clocks. The address wraps from 511 to 0.
- R4: A frame with bits 5..8 equal to 0,0,1,1 sets the write-enable latch. Bits 5..8 equal to 0,0,0,0 clear it. Reset also clears it.
- R5: In a WRITE frame, bits 5..7 are 0,1,0 and the address is placed as in R2. Bits 17..32 carry data bits 0..15. At the 32nd rising edge, one `wr_req` pulse carries the address and data, but only when the latch is set and the write-control input is low.
- R6: Chip select high ends any command, including a read in progress, and returns to standby. `sdo_en` is low while chip select is high.
- R7: The write-control input has no effect on READ, enable or disable frames.
- R8: With chip select low and no read streaming, the data output is 1 when ready and 0 while `busy` is high. Any frame decoded while `busy` is high is ignored.
- R9: A frame whose bits 5..8 match no command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, sampled on rising sck |
| wc | input | 1 | Write control, high blocks WRITE |
| sdo | output | 1 | Serial data out / ready status |
| sdo_en | output | 1 | Output driver enable (low = high impedance) |
| mem_addr | output | 9 | Read address to word array |
| mem_rdata | input | 16 | Read data, one clock after mem_addr |
| wr_req | output | 1 | One-cycle program request |
| wr_addr | output | 9 | Address to program |
| wr_data | output | 16 | Word to program |
| busy | input | 1 | Program-cycle controller busy |

## Verification
Reads are tried at the lowest address, at a mixed-bit address, at the top address streaming across the wrap, and at addresses with one, two and three streamed words. This separates errors in address bit order, in data bit order and in address increment. The write-control level alternates across the reads. WRITE frames are sent with the latch clear, with it set, with write control high and after a reset, so that each gating term is told apart. Frames with a bad start pattern, an unknown opcode, a command issued while busy, and a read cut short by chip select show whether each ignored case leaves the latch and the output state as they were.

// File: rtl/serial_eeprom_front.sv
module serial_eeprom_front (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        sdi,
  input  logic        wc,
  output logic        sdo,
  output logic        sdo_en,
  output logic [8:0]  mem_addr,
  input  logic [15:0] mem_rdata,
  output logic        wr_req,
  output logic [8:0]  wr_addr,
  output logic [15:0] wr_data,
  input  logic        busy
);

  typedef enum logic [2:0] {S_CMD, S_READ, S_WDATA, S_REJ, S_DONE} st_t;

  logic [2:0]  cs_sy, sck_sy;
  logic [1:0]  sdi_sy, wc_sy;
  logic        cs_act, sck_rise, sck_fall, sdi_s, wc_s;
  st_t         st;
  logic [5:0]  cnt;
  logic [15:0] cmd, cmd_nx, wdat, wdat_nx, word;
  logic [3:0]  bidx;
  logic [8:0]  addr_q;
  logic [1:0]  fetch;
  logic        wen_q, sdo_r;
  logic [2:0]  op;
  logic        is_rd, is_wr, is_en, is_ds;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy  <= 3'b111;
      sck_sy <= 3'b000;
      sdi_sy <= 2'b00;
      wc_sy  <= 2'b00;
    end else begin
      cs_sy  <= {cs_sy[1:0], cs_n};
      sck_sy <= {sck_sy[1:0], sck};
      sdi_sy <= {sdi_sy[0], sdi};
      wc_sy  <= {wc_sy[0], wc};
    end

  assign cs_act   = ~cs_sy[1];
  assign sck_rise = sck_sy[1] & ~sck_sy[2];
  assign sck_fall = ~sck_sy[1] & sck_sy[2];
  assign sdi_s    = sdi_sy[1];
  assign wc_s     = wc_sy[1];

  always_comb begin
    cmd_nx = cmd;
    cmd_nx[cnt[3:0]] = sdi_s;
    wdat_nx = wdat;
    wdat_nx[cnt[3:0]] = sdi_s;
  end

  assign op    = {cmd_nx[4], cmd_nx[5], cmd_nx[6]};
  assign is_rd = op == 3'b100;
  assign is_wr = op == 3'b010;
  assign is_en = op == 3'b001 && cmd_nx[7];
  assign is_ds = op == 3'b000 && !cmd_nx[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_CMD;
      cnt     <= '0;
      cmd     <= '0;
      wdat    <= '0;
      word    <= '0;
      bidx    <= '0;
      addr_q  <= '0;
      fetch   <= '0;
      wen_q   <= 1'b0;
      sdo_r   <= 1'b0;
      wr_req  <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_req <= 1'b0;
      if (fetch == 2'd1) fetch <= 2'd2;
      if (fetch == 2'd2) begin
        word  <= mem_rdata;
        fetch <= 2'd0;
      end
      if (!cs_act) begin
        st  <= S_CMD;
        cnt <= '0;
      end else if (sck_rise) begin
        case (st)
          S_CMD: begin
            cnt <= cnt + 6'd1;
            cmd <= cmd_nx;
            if (cnt < 6'd4 && sdi_s != ~cnt[0]) st <= S_REJ;
            else if (cnt == 6'd15) begin
              if (busy) st <= S_DONE;
              else if (is_rd) begin
                addr_q <= {cmd_nx[15:8], cmd_nx[7]};
                fetch  <= 2'd1;
                bidx   <= '0;
                st     <= S_READ;
              end else if (is_wr) begin
                addr_q <= {cmd_nx[15:8], cmd_nx[7]};
                st     <= S_WDATA;
              end else begin
                if (is_en) wen_q <= 1'b1;
                if (is_ds) wen_q <= 1'b0;
                st <= S_DONE;
              end
            end
          end
          S_WDATA: begin
            cnt  <= cnt + 6'd1;
            wdat <= wdat_nx;
            if (cnt == 6'd31) begin
              if (wen_q && !wc_s) begin
                wr_req  <= 1'b1;
                wr_data <= wdat_nx;
              end
              st <= S_DONE;
            end
          end
          default: ;
        endcase
      end else if (sck_fall && st == S_READ) begin
        sdo_r <= word[bidx];
        bidx  <= bidx + 4'd1;
        if (bidx == 4'd15) begin
          addr_q <= addr_q + 9'd1;
          fetch  <= 2'd1;
        end
      end
    end

  assign mem_addr = addr_q;
  assign wr_addr  = addr_q;
  assign sdo_en   = cs_act;
  assign sdo      = (st == S_READ) ? sdo_r : ~busy;

  // R6
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (st == S_CMD && cnt == 6'd0));

  // R4
  wen_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wen_q) |-> ($past(sck_rise) && $past(cnt) == 6'd15 && $past(st) == S_CMD));

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  // R5
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wen_q);

  // R3
  addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> $past(sck_rise || sck_fall));

  // R8
  busy_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_act && sck_rise && st == S_CMD && cnt == 6'd15) |=> (st == S_DONE || st == S_REJ));

endmodule

// File: tb/serial_eeprom_front_tb.sv
module serial_eeprom_front_tb_top;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, sdi = 0, wc = 0, busy = 0;
  logic sdo, sdo_en, wr_req;
  logic [8:0] mem_addr, wr_addr;
  logic [15:0] mem_rdata, wr_data;
  int checks = 0, errors = 0, wr_n = 0;
  logic [8:0] wr_a;
  logic [15:0] wr_d;

  always #5 clk = ~clk;

  serial_eeprom_front dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .wc(wc), .sdo(sdo), .sdo_en(sdo_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy));

  function automatic logic [15:0] mval(input logic [8:0] a);
    return (16'(a) * 16'd257) ^ 16'hA5C3;
  endfunction

  always @(posedge clk) mem_rdata <= mval(mem_addr);

  always @(posedge clk)
    if (wr_req) begin
      wr_n <= wr_n + 1;
      wr_a <= wr_addr;
      wr_d <= wr_data;
    end

  // {wc, words, addr}
  localparam logic [11:0] VEC [5] = '{
    {1'b0, 2'd1, 9'd0}, {1'b1, 2'd2, 9'h1A5}, {1'b0, 2'd2, 9'd511},
    {1'b1, 2'd3, 9'h0FF}, {1'b0, 2'd1, 9'h100}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic s);
    sdi = b;
    repeat (5) @(negedge clk);
    s = sdo;
    sck = 1;
    repeat (5) @(negedge clk);
    sck = 0;
  endtask

  task automatic open_cs;
    cs_n = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic close_cs;
    repeat (8) @(negedge clk);
    cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send16(input logic [15:0] f);
    logic s;
    for (int k = 0; k < 16; k++) bit_io(f[k], s);
  endtask

  function automatic logic [15:0] rd_f(input logic [8:0] a);
    return {a[8:1], a[0], 3'b001, 4'b0101};
  endfunction
  function automatic logic [15:0] wr_f(input logic [8:0] a);
    return {a[8:1], a[0], 3'b010, 4'b0101};
  endfunction
  localparam logic [15:0] WEN_F = {8'h5A, 4'b1100, 4'b0101};
  localparam logic [15:0] WDS_F = {8'hC3, 4'b0000, 4'b0101};

  task automatic frame(input logic [15:0] f);
    open_cs;
    send16(f);
    close_cs;
  endtask

  task automatic write_frame(input logic [8:0] a, input logic [15:0] d);
    logic s;
    open_cs;
    send16(wr_f(a));
    for (int k = 0; k < 16; k++) bit_io(d[k], s);
    close_cs;
  endtask

  task automatic read_words(input logic [8:0] a, input int nw, input string req);
    logic s;
    logic [15:0] got;
    open_cs;
    send16(rd_f(a));
    for (int w = 0; w < nw; w++) begin
      for (int k = 0; k < 16; k++) begin
        bit_io(1'b0, s);
        got[k] = s;
      end
      chk(req, {16'd0, got}, {16'd0, mval(a + 9'(w))});
    end
    close_cs;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    logic s;
    logic [15:0] got;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R6 reset state: driver off, no request
    chk("R6", {31'd0, sdo_en}, 32'd0);
    chk("R5", wr_n, 0);

    // R2 R3 R7: read vectors, wc alternates
    for (int v = 0; v < 5; v++) begin
      wc = VEC[v][11];
      read_words(VEC[v][8:0], int'(VEC[v][10:9]), "R2_R3_R7");
    end
    wc = 0;

    // R4: write with latch clear is dropped
    write_frame(9'h033, 16'h1234);
    chk("R4", wr_n, 0);

    // R7 R5: enable issued with wc high, then write goes through
    wc = 1;
    frame(WEN_F);
    wc = 0;
    write_frame(9'h16B, 16'hBEEF);
    chk("R5", wr_n, 1);
    chk("R5", {23'd0, wr_a}, {23'd0, 9'h16B});
    chk("R5", {16'd0, wr_d}, 32'h0000BEEF);

    // R5: wc high blocks write
    wc = 1;
    write_frame(9'h001, 16'h0F0F);
    wc = 0;
    chk("R5", wr_n, 1);

    // R1: disable frame with bad start is ignored, latch stays set
    frame({WDS_F[15:4], 4'b0100});
    write_frame(9'h0AA, 16'h8001);
    chk("R1", wr_n, 2);
    chk("R1", {16'd0, wr_d}, 32'h00008001);

    // R9: unknown opcode ignored, latch stays set
    frame({8'hFF, 4'b0011, 4'b0101});
    write_frame(9'h155, 16'h7E7E);
    chk("R9", wr_n, 3);

    // R7 R4: disable with wc high clears latch
    wc = 1;
    frame(WDS_F);
    wc = 0;
    write_frame(9'h002, 16'h2222);
    chk("R4", wr_n, 3);

    // R8: status on output and command ignored while busy
    open_cs;
    chk("R8", {31'd0, sdo}, 32'd1);
    busy = 1;
    repeat (2) @(negedge clk);
    chk("R8", {31'd0, sdo}, 32'd0);
    send16(WEN_F);
    close_cs;
    busy = 0;
    write_frame(9'h003, 16'h3333);
    chk("R8", wr_n, 3);

    // R6: chip select high cuts a read short
    frame(WEN_F);
    open_cs;
    send16(rd_f(9'h0C0));
    for (int k = 0; k < 5; k++) bit_io(1'b0, s);
    cs_n = 1;
    repeat (6) @(negedge clk);
    chk("R6", {31'd0, sdo_en}, 32'd0);
    repeat (4) @(negedge clk);
    read_words(9'h0C1, 1, "R6");

    // R4: reset clears the latch
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    n0 = wr_n;
    write_frame(9'h004, 16'h4444);
    chk("R4", wr_n, n0);

    // R2: status bit visible before frame, then read still correct
    open_cs;
    chk("R8", {31'd0, sdo_en}, 32'd1);
    send16(rd_f(9'h1FE));
    for (int k = 0; k < 16; k++) begin
      bit_io(1'b0, s);
      got[k] = s;
    end
    chk("R2", {16'd0, got}, {16'd0, mval(9'h1FE)});
    close_cs;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule